// File: doc/BRIEF.md
# Serial Receive Queue with Fill-Level and Timeout Interrupts

This block is the receive side of an asynchronous serial port. It watches a single idle-high line and rebuilds bytes that are sent as one start bit, eight data bits with the least significant bit first, and one stop bit. It times the bits with a sample tick at sixteen times the baud rate, and the divisor that sets that tick is a runtime input. Every byte it recovers goes into a small queue. The host takes bytes out through a show-ahead data port and a one-cycle read strobe.

The block does not interrupt on every byte. It raises a level-style request when the queue holds at least a programmable number of bytes. A second request covers a short burst that never reaches that count: it fires when some bytes wait in the queue and no byte has arrived and no read has occurred for forty bit periods. Each request has its own enable. The host drains the queue until it reports empty, and both requests then drop.

The receive engine is a five-state machine with the states `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP` and `RX_HOLD`. The transitions are:
- idle to start, when a sample tick sees the line low;
- start to idle, when the line is high again at mid start bit (a glitch);
- start to data, when the line is still low at mid start bit;
- data to stop, after the eighth data bit is taken;
- stop to idle, when the stop bit is high;
- stop to hold, when the stop bit is low;
- hold to idle, when the line returns high.

Top module: `serial_rx_queue`

## Requirements
- R1: The sample tick recurs every `baud_div`+1 clocks, and a bit lasts 16 ticks. Each data bit is taken 16 ticks after the previous sample point, which lands in the middle of the bit. The eight data bits arrive least significant first, and the byte is queued at the middle of the stop bit.
- R2: The line must be low on the first tick and still low 8 ticks later. A low pulse that is gone by that second check returns the engine to idle, and nothing is queued.
- R3: A stop bit sampled low still queues the byte and sets the sticky `frame_err` flag. The engine then waits for the line to go high, so a held-low line queues no second byte.
- R4: Bytes leave the queue in arrival order. `rd_data` always shows the oldest byte, and `rd_stb` removes it. A strobe while the queue is empty changes nothing.
- R5: A byte that arrives while the queue holds DEPTH bytes discards the oldest byte, keeps the newest, and sets the sticky `overrun` flag. A `clr_flags` pulse clears both `overrun` and `frame_err`.
- R6: `pend_lvl` is high exactly when `level` is nonzero and at least `thresh`.
- R7: `pend_tmo` rises when 0 < `level` < `thresh` and there has been no new byte and no `rd_stb` for 640 ticks. Each new byte and each read restarts that interval.
- R8: While `level` is 0, both `pend_lvl` and `pend_tmo` are low.
- R9: `irq` equals (`en_lvl` AND `pend_lvl`) OR (`en_tmo` AND `pend_tmo`).
- R10: `empty` is high when `level` is 0, and `full` is high when `level` equals DEPTH.
- R11: After reset the queue is empty, both flags are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| baud_div | input | 16 | Sample tick period minus one, in clocks |
| rd_stb | input | 1 | Removes the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte |
| thresh | input | 4 | Fill level that raises pend_lvl |
| en_lvl | input | 1 | Enable for the fill-level request |
| en_tmo | input | 1 | Enable for the timeout request |
| clr_flags | input | 1 | Clears overrun and frame_err |
| level | output | 4 | Number of queued bytes |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds DEPTH bytes |
| overrun | output | 1 | Sticky: a byte was discarded |
| frame_err | output | 1 | Sticky: a stop bit was low |
| pend_lvl | output | 1 | Fill-level condition pending |
| pend_tmo | output | 1 | Timeout condition pending |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DEPTH 8, so nine back-to-back bytes are enough to reach the discard-oldest overrun case. It uses a threshold of 4, which makes both the below-threshold timeout and the at-threshold request reachable with a few frames. `baud_div` is 1 for most scenarios: one frame is then 320 clocks and the timeout interval is 1280 clocks, so the bench can probe the timeout on both sides of its edge and also test the restart on a read. One scenario switches `baud_div` to 3 at run time to confirm that the divisor really sets the bit timing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int OVS = 16;
    localparam int MID = OVS / 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;
endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
    import rxq_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             push_o,
    output logic [7:0]       data_o,
    output logic             ferr_o
);
    localparam int SW = $clog2(OVS);

    logic [1:0]       sync_q;
    logic             line_s;
    logic [DIV_W-1:0] div_cnt;
    logic [SW-1:0]    smp;
    logic [2:0]       bitn;
    rx_state_t        state, nxt;

    assign line_s = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            div_cnt <= '0;
            tick_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (div_cnt >= div_i) begin
                div_cnt <= '0;
                tick_o  <= 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
                tick_o  <= 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick_o && !line_s) nxt = RX_START;
            RX_START: if (tick_o && smp == SW'(MID - 1))
                          nxt = line_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_o && smp == SW'(OVS - 1) && bitn == 3'd7)
                          nxt = RX_STOP;
            RX_STOP:  if (tick_o && smp == SW'(OVS - 1))
                          nxt = line_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (tick_o && line_s) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp    <= '0;
            bitn   <= '0;
            data_o <= '0;
            push_o <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            push_o <= 1'b0;
            ferr_o <= 1'b0;
            if (tick_o) begin
                smp <= (nxt != state) ? '0 : smp + 1'b1;
                if (state == RX_START) bitn <= '0;
                if (state == RX_DATA && smp == SW'(OVS - 1)) begin
                    data_o <= {line_s, data_o[7:1]};
                    bitn   <= bitn + 1'b1;
                end
                if (state == RX_STOP && smp == SW'(OVS - 1)) begin
                    push_o <= 1'b1;
                    ferr_o <= !line_s;
                end
            end
        end
    end

    p_push_ends_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (state == RX_IDLE || state == RX_HOLD));

    p_hold_while_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && !line_s) |=> state == RX_HOLD);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_pop, drop;

    assign do_pop  = pop_i && level_o != '0;
    assign drop    = push_i && level_o == CW'(DEPTH) && !do_pop;
    assign drop_o  = drop;
    assign rdata_o = mem[rp];

    always_ff @(posedge clk) begin
        if (push_i) mem[wp] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            level_o <= '0;
        end else begin
            if (push_i)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop || drop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push_i && !do_pop && !drop)
                level_o <= level_o + 1'b1;
            else if (do_pop && !push_i)
                level_o <= level_o - 1'b1;
        end
    end

    p_full_push_stays_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == CW'(DEPTH) && push_i && !pop_i) |=> level_o == CW'(DEPTH));

    p_empty_read_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0 && pop_i && !push_i) |=> level_o == '0);

    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != CW'(DEPTH) && push_i && !pop_i) |=> level_o == $past(level_o) + 1'b1);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
    parameter int CW        = 4,
    parameter int TMO_TICKS = 640
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [CW-1:0] level_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          en_lvl_i,
    input  logic          en_tmo_i,
    output logic          pend_lvl_o,
    output logic          pend_tmo_o,
    output logic          irq_o
);
    localparam int TW = $clog2(TMO_TICKS + 1);

    logic [TW-1:0] tcnt;
    logic          hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            hit  <= 1'b0;
        end else if (push_i || pop_i || level_i == '0) begin
            tcnt <= '0;
            hit  <= 1'b0;
        end else if (tick_i && !hit) begin
            if (tcnt == TW'(TMO_TICKS - 1)) hit <= 1'b1;
            else                            tcnt <= tcnt + 1'b1;
        end
    end

    assign pend_lvl_o = level_i != '0 && level_i >= thresh_i;
    assign pend_tmo_o = hit && level_i != '0 && level_i < thresh_i;
    assign irq_o      = (en_lvl_i && pend_lvl_o) || (en_tmo_i && pend_tmo_o);

    p_tmo_after_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_tmo_o) |-> $past(!push_i && !pop_i));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
    parameter int DEPTH    = 8,
    parameter int DIV_W    = 16,
    parameter int TMO_BITS = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_line,
    input  logic [DIV_W-1:0]           baud_div,
    input  logic                       rd_stb,
    output logic [7:0]                 rd_data,
    input  logic [$clog2(DEPTH+1)-1:0] thresh,
    input  logic                       en_lvl,
    input  logic                       en_tmo,
    input  logic                       clr_flags,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full,
    output logic                       overrun,
    output logic                       frame_err,
    output logic                       pend_lvl,
    output logic                       pend_tmo,
    output logic                       irq
);
    localparam int CW        = $clog2(DEPTH + 1);
    localparam int TMO_TICKS = TMO_BITS * rxq_pkg::OVS;

    logic       tick, push, ferr, drop;
    logic [7:0] rx_byte;

    rxq_sampler #(.DIV_W(DIV_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .line_i(rx_line), .div_i(baud_div),
        .tick_o(tick), .push_o(push), .data_o(rx_byte), .ferr_o(ferr)
    );

    rxq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(rx_byte),
        .pop_i(rd_stb), .rdata_o(rd_data), .level_o(level), .drop_o(drop)
    );

    rxq_irq #(.CW(CW), .TMO_TICKS(TMO_TICKS)) u_irq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .push_i(push), .pop_i(rd_stb),
        .level_i(level), .thresh_i(thresh), .en_lvl_i(en_lvl), .en_tmo_i(en_tmo),
        .pend_lvl_o(pend_lvl), .pend_tmo_o(pend_tmo), .irq_o(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            overrun   <= drop || (overrun && !clr_flags);
            frame_err <= (push && ferr) || (frame_err && !clr_flags);
        end
    end

    assign empty = level == '0;
    assign full  = level == CW'(DEPTH);

    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (!pend_lvl && !pend_tmo && !irq));

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_flags) |=> overrun);
endmodule

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [15:0] baud_div = 16'd1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] thresh = 4'd4;
    logic       en_lvl = 1'b0, en_tmo = 1'b0, clr_flags = 1'b0;
    logic [3:0] level;
    logic       empty, full, overrun, frame_err, pend_lvl, pend_tmo, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_queue u_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
        .rd_stb(rd_stb), .rd_data(rd_data), .thresh(thresh), .en_lvl(en_lvl),
        .en_tmo(en_tmo), .clr_flags(clr_flags), .level(level), .empty(empty),
        .full(full), .overrun(overrun), .frame_err(frame_err),
        .pend_lvl(pend_lvl), .pend_tmo(pend_tmo), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v);
        rx_line = v;
        wait_clk(16 * (int'(baud_div) + 1));
    endtask

    task automatic send(input logic [7:0] b, input logic stop_v);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop_v);
        rx_line = 1'b1;
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(rd_data == exp, tag, rd_data, exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic t_reset();
        wait_clk(3);
        check(empty && level == 0, "R11 empty after reset", level, 0);
        check(!full && !overrun && !frame_err, "R11 flags clear", {full, overrun, frame_err}, 0);
        check(!irq, "R11 irq low", irq, 0);
        check(empty && !full, "R10 empty/full at zero", {empty, full}, 2);
    endtask

    task automatic t_single_and_timeout();
        en_tmo = 1'b0;
        send(8'hA5, 1'b1);
        wait_clk(4);
        check(level == 1, "R1 one byte queued", level, 1);
        check(rd_data == 8'hA5, "R1 byte value LSB first", rd_data, 8'hA5);
        check(!pend_lvl, "R6 below threshold", pend_lvl, 0);
        wait_clk(900);
        check(!pend_tmo, "R7 no timeout before 640 ticks", pend_tmo, 0);
        wait_clk(500);
        check(pend_tmo, "R7 timeout after quiet interval", pend_tmo, 1);
        check(!irq, "R9 timeout masked", irq, 0);
        en_tmo = 1'b1;
        @(negedge clk);
        check(irq, "R9 timeout enabled raises irq", irq, 1);
        pop_expect(8'hA5, "R4 drain single");
        check(empty && !pend_tmo && !irq, "R8 requests drop when empty", {pend_tmo, irq}, 0);
    endtask

    task automatic t_empty_read();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        wait_clk(2);
        check(level == 0 && empty, "R4 read of empty ignored", level, 0);
    endtask

    task automatic t_threshold();
        en_lvl = 1'b1;
        for (int i = 0; i < 4; i++) send(8'h30 + 8'(i), 1'b1);
        wait_clk(4);
        check(level == 4, "R6 four bytes queued", level, 4);
        check(pend_lvl && irq, "R6 R9 threshold request", {pend_lvl, irq}, 3);
        wait_clk(1500);
        check(!pend_tmo, "R7 no timeout at threshold", pend_tmo, 0);
        for (int i = 0; i < 4; i++) pop_expect(8'h30 + 8'(i), "R4 arrival order");
        check(!pend_lvl && !irq, "R8 drained clears request", {pend_lvl, irq}, 0);
        en_lvl = 1'b0;
    endtask

    task automatic t_timeout_restart();
        send(8'h41, 1'b1);
        send(8'h42, 1'b1);
        wait_clk(900);
        pop_expect(8'h41, "R4 first of two");
        wait_clk(900);
        check(!pend_tmo, "R7 read restarts interval", pend_tmo, 0);
        wait_clk(600);
        check(pend_tmo, "R7 timeout after restart", pend_tmo, 1);
        pop_expect(8'h42, "R4 second of two");
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 9; i++) send(8'h10 + 8'(i), 1'b1);
        wait_clk(4);
        check(full && level == 8, "R10 full at DEPTH", level, 8);
        check(overrun, "R5 overrun set", overrun, 1);
        for (int i = 1; i < 9; i++) pop_expect(8'h10 + 8'(i), "R5 oldest dropped");
        check(empty, "R5 queue drained", level, 0);
        check(overrun, "R5 overrun sticky", overrun, 1);
        pulse_clear();
        check(!overrun, "R5 clear flags", overrun, 0);
    endtask

    task automatic t_framing();
        send(8'h5C, 1'b0);
        rx_line = 1'b0;
        wait_clk(3 * 32);
        rx_line = 1'b1;
        wait_clk(64);
        check(level == 1, "R3 one byte for bad frame", level, 1);
        check(frame_err, "R3 framing flag", frame_err, 1);
        pop_expect(8'h5C, "R3 byte kept");
        pulse_clear();
        check(!frame_err, "R5 clear framing flag", frame_err, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rx_line = 1'b0;
        wait_clk(8);
        rx_line = 1'b1;
        wait_clk(400);
        check(level == 0, "R2 glitch ignored", level, 0);
    endtask

    task automatic t_divisor();
        baud_div = 16'd3;
        wait_clk(10);
        send(8'hC3, 1'b1);
        wait_clk(8);
        check(level == 1, "R1 divisor 3 byte queued", level, 1);
        pop_expect(8'hC3, "R1 divisor 3 value");
        baud_div = 16'd1;
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        t_reset();
        t_single_and_timeout();
        t_empty_read();
        t_threshold();
        t_timeout_restart();
        t_overrun();
        t_framing();
        t_glitch();
        t_divisor();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule